// File: doc/BRIEF.md
# Control Packet Serializer with CRC

This block turns one register-access command from a host into the byte stream of an uplink control request for a camera link. The host offers a command on a valid/ready handshake. The command says read or write, tagged or untagged, and 32-bit or 64-bit register width. It also carries an address, write data and an 8-bit tag. The block then sends the request one byte per cycle on a valid/ready output stream.

The packet is built in order. It opens with a repeated type byte, then an optional repeated tag, then a command/size word and a big-endian address. Write requests add big-endian data. The packet closes with a CRC-32 trailer, which the block computes on the fly as the body bytes are accepted downstream. Line coding, packet framing symbols and acknowledge handling belong to neighbouring blocks.

Top module: `ctl_pkt_ser`

## Requirements
- R1: After reset `out_valid` is low and `cmd_ready` is high.
- R2: Every packet begins with four copies of a type byte: 0x02 when `cmd_tagged` is 0, 0x05 when it is 1.
- R3: In a tagged packet, four copies of `cmd_tag` follow the type bytes. An untagged packet has no tag bytes.
- R4: A command/size word follows as four bytes, in this order: 0x01 for a write or 0x00 for a read, then 0x00, then 0x00, then 0x08 when `cmd_wide` is 1 or 0x04 when it is 0.
- R5: The 32-bit `cmd_addr` follows the command/size word, most significant byte first.
- R6: A write then carries its data most significant byte first: `cmd_data[31:0]` as 4 bytes when narrow, or all of `cmd_data` as 8 bytes when wide. A read carries no data bytes.
- R7: Four checksum bytes close the packet, least significant byte first. Their value is the bitwise complement of the IEEE CRC-32 (reflected, polynomial 0xEDB88320, initial value and final XOR 0xFFFFFFFF). The CRC is taken over every byte from the first byte after the type bytes to the last address or data byte.
- R8: Untagged packets are 16 bytes for a read and 20 or 24 bytes for a narrow or wide write. Tagged packets are 4 bytes longer. `out_last` is high on the final checksum byte and on no other byte.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_last` hold their values into the next cycle.
- R10: `cmd_ready` is low while a packet is in flight. The command fields are captured when the command is accepted, so later changes to them have no effect. The block is idle again in the cycle after the final byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_write | input | 1 | 1 = write request, 0 = read request |
| cmd_tagged | input | 1 | 1 = tagged request |
| cmd_wide | input | 1 | 1 = 64-bit register, 0 = 32-bit register |
| cmd_addr | input | 32 | Register address |
| cmd_data | input | 64 | Write data (low 32 bits used when narrow) |
| cmd_tag | input | 8 | Request tag |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Packet byte |
| out_last | output | 1 | Final byte of the packet |

## Verification
The hardest case to reach is a checksum that stays correct while the downstream stalls. This matters most on the last body byte and the first trailer byte, where a double or missed CRC update would still produce a well-formed packet. The stimulus holds `out_ready` low on a repeating pattern of cycles while walking every packet variant, so stalls land on body bytes, trailer bytes and the final byte. Every byte is compared with a reference sequence built in the bench. In the same runs the bench keeps `cmd_valid` high with changed fields during the packet, to show that they are captured once and that no second packet starts early.

// File: rtl/ctl_pkt_ser.sv
module ctl_pkt_ser #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic              cmd_tagged,
  input  logic              cmd_wide,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_last
);
  localparam int IW = 5;
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic              busy;
  logic [IW-1:0]     idx;
  logic              wr_q, tag_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [TAG_W-1:0]  tagv_q;
  logic [31:0]       crc_q;

  wire [IW-1:0] hdr_end  = tag_q ? IW'(8) : IW'(4);
  wire [IW-1:0] dlen     = !wr_q ? IW'(0) : (wide_q ? IW'(8) : IW'(4));
  wire [IW-1:0] body_end = hdr_end + IW'(8) + dlen;
  wire [IW-1:0] last_idx = body_end + IW'(3);
  wire [IW-1:0] rel      = idx - hdr_end;
  wire [IW-1:0] drel     = rel - IW'(8);
  wire [IW-1:0] crel     = idx - body_end;
  wire          beat     = busy && out_ready;
  wire          crc_en   = beat && idx >= IW'(4) && idx < body_end;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int k = 0; k < 8; k++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  always_comb begin
    if (idx < IW'(4))
      out_byte = tag_q ? 8'h05 : 8'h02;
    else if (idx < hdr_end)
      out_byte = tagv_q;
    else if (rel < IW'(4))
      case (rel[1:0])
        2'd0:    out_byte = {7'd0, wr_q};
        2'd3:    out_byte = wide_q ? 8'h08 : 8'h04;
        default: out_byte = 8'h00;
      endcase
    else if (rel < IW'(8))
      out_byte = addr_q[{~rel[1:0], 3'b000} +: 8];
    else if (idx < body_end)
      out_byte = wide_q ? data_q[{~drel[2:0], 3'b000} +: 8]
                        : data_q[{1'b0, ~drel[1:0], 3'b000} +: 8];
    else
      out_byte = crc_q[{crel[1:0], 3'b000} +: 8];
  end

  assign cmd_ready = !busy;
  assign out_valid = busy;
  assign out_last  = busy && idx == last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      crc_q  <= '1;
      wr_q   <= 1'b0;
      tag_q  <= 1'b0;
      wide_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      tagv_q <= '0;
    end else if (!busy && cmd_valid) begin
      busy   <= 1'b1;
      idx    <= '0;
      crc_q  <= '1;
      wr_q   <= cmd_write;
      tag_q  <= cmd_tagged;
      wide_q <= cmd_wide;
      addr_q <= cmd_addr;
      data_q <= cmd_data;
      tagv_q <= cmd_tag;
    end else if (beat) begin
      idx <= idx + IW'(1);
      if (crc_en) crc_q <= crc_step(crc_q, out_byte);
      if (idx == last_idx) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_pkt_ser_chk.sv
module ctl_pkt_ser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_last,
  input logic [7:0] out_byte
);
  logic [5:0] n;

  always_ff @(posedge clk) begin
    if (!rst_n) n <= '0;
    else if (cmd_valid && cmd_ready) n <= '0;
    else if (out_valid && out_ready) n <= n + 6'd1;
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_last)); // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cmd_ready); // R10
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && cmd_ready); // R10
  AST_TYPE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> out_valid && (out_byte == 8'h02 || out_byte == 8'h05)); // R2
  AST_LEGAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |-> (n == 6'd15 || n == 6'd19 || n == 6'd23 || n == 6'd27)); // R8
endmodule

bind ctl_pkt_ser ctl_pkt_ser_chk u_chk (.*);

// File: tb/sim_ctl_pkt_ser.sv
`timescale 1ns/1ps
module sim_ctl_pkt_ser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_tagged = 1'b0, cmd_wide = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [63:0] cmd_data = '0;
  logic [7:0]  cmd_tag = '0;
  logic        out_ready = 1'b0;
  logic        cmd_ready, out_valid, out_last;
  logic [7:0]  out_byte;

  int checks = 0, fails = 0, cyc_all = 0;
  logic [7:0] exp_b [0:31];
  int exp_len;
  int hdr_len;

  always #5 clk = ~clk;

  ctl_pkt_ser u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ieee_crc(input int from, input int upto);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = from; i < upto; i++) begin
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ exp_b[i][k]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    return ~c;
  endfunction

  task automatic put(input logic [7:0] b);
    exp_b[exp_len] = b;
    exp_len++;
  endtask

  task automatic build_ref(input bit w, input bit t, input bit wd,
                           input logic [31:0] a, input logic [63:0] d, input logic [7:0] tg);
    logic [31:0] tx;
    exp_len = 0;
    for (int i = 0; i < 4; i++) put(t ? 8'h05 : 8'h02);
    if (t) for (int i = 0; i < 4; i++) put(tg);
    hdr_len = exp_len;
    put(w ? 8'h01 : 8'h00); put(8'h00); put(8'h00); put(wd ? 8'h08 : 8'h04);
    for (int i = 3; i >= 0; i--) put(a[8*i +: 8]);
    if (w) for (int i = (wd ? 7 : 3); i >= 0; i--) put(d[8*i +: 8]);
    tx = ~ieee_crc(4, exp_len);
    for (int i = 0; i < 4; i++) put(tx[8*i +: 8]);
  endtask

  function automatic string region(input int i);
    if (i < 4) return "R2";
    if (i < hdr_len) return "R3";
    if (i < hdr_len + 4) return "R4";
    if (i < hdr_len + 8) return "R5";
    if (i < exp_len - 4) return "R6";
    return "R7";
  endfunction

  task automatic run_pkt(input bit w, input bit t, input bit wd, input logic [31:0] a,
                         input logic [63:0] d, input logic [7:0] tg, input bit stall, input bit hold);
    int got = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [7:0] prev_b = '0;
    bit prev_last = 0;
    bit rdy;
    build_ref(w, t, wd, a, d, tg);
    @(negedge clk);
    cmd_write = w; cmd_tagged = t; cmd_wide = wd;
    cmd_addr = a; cmd_data = d; cmd_tag = tg;
    cmd_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    if (!hold) cmd_valid = 1'b0;
    cmd_write = ~w; cmd_tagged = ~t; cmd_wide = ~wd;
    cmd_addr = ~a; cmd_data = ~d; cmd_tag = ~tg;
    while (got < exp_len && cyc < 200) begin
      if (prev_stall) begin
        chk(out_valid && out_byte == prev_b && out_last == prev_last,
            "R9", "held byte", {55'd0, out_valid, out_byte}, {55'd0, 1'b1, prev_b});
      end
      if (hold && out_valid) chk(!cmd_ready, "R10", "cmd_ready busy", cmd_ready, 0);
      rdy = !(stall && (cyc % 3 == 1));
      out_ready = rdy;
      if (out_valid && rdy) begin
        chk(out_byte == exp_b[got], region(got), $sformatf("byte %0d", got),
            out_byte, exp_b[got]);
        chk(out_last == (got == exp_len - 1), "R8", $sformatf("out_last at %0d", got),
            out_last, (got == exp_len - 1));
        got++;
        if (got == exp_len) cmd_valid = 1'b0;
      end
      prev_stall = out_valid && !rdy;
      prev_b = out_byte;
      prev_last = out_last;
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(got == exp_len, "R8", "packet length", got, exp_len);
    chk(!out_valid && cmd_ready, "R10", "idle after last", {out_valid, cmd_ready}, 2'b01);
  endtask

  task automatic t_reset;
    chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
    chk(cmd_ready, "R1", "cmd_ready after reset", cmd_ready, 1);
  endtask

  task automatic t_ref_sanity;
    string s = "123456789";
    for (int i = 0; i < 9; i++) exp_b[i] = s[i];
    chk(ieee_crc(0, 9) == 32'hCBF43926, "R7", "reference CRC", ieee_crc(0, 9), 32'hCBF43926);
  endtask

  task automatic t_untagged;
    run_pkt(0, 0, 0, 32'h0000_0000, 64'h0, 8'h00, 0, 0);
    run_pkt(1, 0, 0, 32'h0000_00FF, 64'hDEAD_BEEF_0000_0032, 8'h00, 0, 0);
    run_pkt(1, 0, 1, 32'h1234_5678, 64'h0102_0304_0506_0708, 8'h00, 1, 0);
    run_pkt(0, 0, 1, 32'hA5A5_5A5A, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 1, 1);
  endtask

  task automatic t_tagged;
    run_pkt(0, 1, 0, 32'h0000_00FF, 64'h0, 8'h44, 1, 1);
    run_pkt(1, 1, 0, 32'h8000_0001, 64'h0000_0000_CAFE_F00D, 8'h9C, 0, 1);
    run_pkt(1, 1, 1, 32'hFEDC_BA98, 64'h0000_0000_0000_0064, 8'hFF, 1, 1);
    run_pkt(0, 1, 1, 32'h0000_1000, 64'h0, 8'h00, 0, 0);
  endtask

  task automatic t_back_to_back;
    run_pkt(1, 0, 1, 32'hFFFF_FFFF, 64'h8877_6655_4433_2211, 8'h00, 0, 1);
    run_pkt(1, 1, 0, 32'h0000_0004, 64'h0000_0000_0000_0001, 8'h01, 1, 0);
  endtask

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc_all);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ref_sanity;
    t_untagged;
    t_tagged;
    t_back_to_back;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule